// File: doc/BRIEF.md
# PS/2 Device Frame Receiver

This block listens to the two open-collector lines of a PS/2 keyboard or mouse and turns each frame the device sends into a byte. The device drives both the clock line and the data line, and the receiver only reads them. Both raw lines first pass through a synchronizer. Each then passes through a run-length filter clocked by the system clock, so that a short spike on either line has no effect.

A falling edge of the filtered PS/2 clock produces a one-cycle sample enable in the system clock domain, and the filtered data line is captured on that enable. When eleven bits have been collected, the frame is checked. The start bit must be 0, the stop bit must be 1, and the eight data bits together with the parity bit must hold an odd number of ones. A good frame gives a one-cycle byte strobe. A bad frame gives a one-cycle error strobe instead.

If a frame stalls part way, a silence timeout drops the partial frame, so the next falling edge is taken as a start bit.

Top module: `ps2_frame_rx`

## Requirements
- R1: A synchronous reset clears the bit position and sets both filtered lines to 1. While reset is asserted and on the first cycle after it, `byte_valid_o` and `frame_err_o` are 0 and `byte_o` is 0. A frame that was partly received before the reset has no effect on the frames that follow it.
- R2: A frame is 11 bits, taken in this order: start, data bit 0 through data bit 7 (least significant first), parity, stop. Bits are taken on falling edges of the filtered PS/2 clock. For a good frame, `byte_o` carries the 8 data bits when `byte_valid_o` goes high.
- R3: Parity is odd over the 8 data bits plus the parity bit. A frame with even parity raises `frame_err_o` and does not raise `byte_valid_o`.
- R4: A frame whose start bit is 1 raises `frame_err_o` and does not raise `byte_valid_o`.
- R5: A frame whose stop bit is 0 raises `frame_err_o` and does not raise `byte_valid_o`.
- R6: Each line's filtered level changes only after RUN_LEN consecutive system-clock samples of the new level; otherwise it holds. A low pulse on the PS/2 clock shorter than RUN_LEN cycles captures no bit. A data pulse shorter than RUN_LEN cycles does not alter the captured bit.
- R7: If a partial frame sees no falling edge for TIMEOUT_CYC system cycles, the bit position returns to 0. The dropped frame produces no strobe.
- R8: `byte_valid_o` and `frame_err_o` are never high together. Each is high for exactly one cycle per completed frame.
- R9: `byte_o` changes only in the cycle where `byte_valid_o` is high. An error frame leaves the last good byte in place.
- R10: After a bad frame, the next frame is received correctly, with no loss of alignment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous reset, active high |
| ps2_clk_i | input | 1 | Raw PS/2 clock line from the device |
| ps2_dat_i | input | 1 | Raw PS/2 data line from the device |
| byte_o | output | 8 | Last byte received in a good frame |
| byte_valid_o | output | 1 | One-cycle strobe for a good frame |
| frame_err_o | output | 1 | One-cycle strobe for a frame with a bad start, parity or stop bit |

## Verification
The assertions assume that the PS/2 clock stays low for well over RUN_LEN system cycles on every real bit. This means a filtered falling edge never comes sooner than a few dozen cycles after the previous one, so strobes cannot come back to back. The stimulus holds each PS/2 clock phase for 40 system cycles and changes data only while the clock is high. Spikes are injected only with widths below RUN_LEN. Silent gaps inside a frame stay far below TIMEOUT_CYC, except in the one scenario that deliberately exceeds it.

// File: rtl/ps2rx_pkg.sv
package ps2rx_pkg;

   localparam int FRAME_BITS = 11;
   localparam int DATA_BITS  = 8;

   // Layout after all bits are shifted in from the top: stop bit in the MSB, start bit in the LSB.
   typedef struct packed {
      logic                 stop_b;
      logic                 par_b;
      logic [DATA_BITS-1:0] payload;
      logic                 start_b;
   } ps2_frame_t;

   function automatic logic frame_good(input ps2_frame_t f);
      return (!f.start_b) && f.stop_b && (^{f.par_b, f.payload});
   endfunction

endpackage

// File: rtl/ps2rx_line_filter.sv
module ps2rx_line_filter #(
   parameter int RUN_LEN     = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_i,
   input  logic line_i,
   output logic line_o
);

   initial begin
      assert (RUN_LEN >= 2) else $error("RUN_LEN must be at least 2");
      assert (SYNC_STAGES >= 0 && SYNC_STAGES <= 4) else $error("SYNC_STAGES out of range");
   end

   logic synced;

   generate
      if (SYNC_STAGES == 0) begin : g_nosync
         assign synced = line_i;
      end else if (SYNC_STAGES == 1) begin : g_sync1
         logic s_q;
         always_ff @(posedge clk_i) begin
            if (rst_i) s_q <= 1'b1;
            else       s_q <= line_i;
         end
         assign synced = s_q;
      end else begin : g_syncn
         logic [SYNC_STAGES-1:0] s_q;
         always_ff @(posedge clk_i) begin
            if (rst_i) s_q <= '1;
            else       s_q <= {s_q[SYNC_STAGES-2:0], line_i};
         end
         assign synced = s_q[SYNC_STAGES-1];
      end
   endgenerate

   logic [RUN_LEN-1:0] win_q;
   logic               filt_q;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         win_q  <= '1;
         filt_q <= 1'b1;
      end else begin
         win_q <= {win_q[RUN_LEN-2:0], synced};
         if (&win_q)
            filt_q <= 1'b1;
         else if (~|win_q)
            filt_q <= 1'b0;
      end
   end

   assign line_o = filt_q;

   // R6: the filtered level moves only after a full window of agreeing samples
   assert_filter_run_R6: assert property (@(posedge clk_i) disable iff (rst_i)
      !$stable(filt_q) |-> ($past(win_q) == {RUN_LEN{filt_q}}));

endmodule

// File: rtl/ps2rx_fall_detect.sv
module ps2rx_fall_detect (
   input  logic clk_i,
   input  logic rst_i,
   input  logic level_i,
   output logic fall_o
);

   logic prev_q;

   always_ff @(posedge clk_i) begin
      if (rst_i) prev_q <= 1'b1;
      else       prev_q <= level_i;
   end

   assign fall_o = prev_q & ~level_i;

   // R2: one sample enable per falling edge
   assert_single_tick_R2: assert property (@(posedge clk_i) disable iff (rst_i)
      fall_o |=> !fall_o);

endmodule

// File: rtl/ps2rx_framer.sv
module ps2rx_framer
   import ps2rx_pkg::*;
#(
   parameter int TIMEOUT_CYC = 200000
) (
   input  logic                 clk_i,
   input  logic                 rst_i,
   input  logic                 sample_i,
   input  logic                 bit_i,
   output logic [DATA_BITS-1:0] data_o,
   output logic                 valid_o,
   output logic                 err_o
);

   localparam int CW = $clog2(FRAME_BITS);
   localparam int TW = $clog2(TIMEOUT_CYC + 1);
   localparam logic [CW-1:0] LAST_POS = CW'(FRAME_BITS - 1);
   localparam logic [TW-1:0] TMO_LAST = TW'(TIMEOUT_CYC - 1);

   initial begin
      assert (TIMEOUT_CYC >= 2) else $error("TIMEOUT_CYC must be at least 2");
   end

   logic [CW-1:0]         pos_q;
   logic [TW-1:0]         idle_q;
   logic [FRAME_BITS-1:0] sh_q;
   logic [FRAME_BITS-1:0] sh_nxt;
   ps2_frame_t            frm_nxt;
   logic                  frm_ok;

   always_comb begin
      sh_nxt  = {bit_i, sh_q[FRAME_BITS-1:1]};
      frm_nxt = ps2_frame_t'(sh_nxt);
      frm_ok  = frame_good(frm_nxt);
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         pos_q   <= '0;
         idle_q  <= '0;
         sh_q    <= '0;
         data_o  <= '0;
         valid_o <= 1'b0;
         err_o   <= 1'b0;
      end else begin
         valid_o <= 1'b0;
         err_o   <= 1'b0;
         if (sample_i) begin
            idle_q <= '0;
            sh_q   <= sh_nxt;
            if (pos_q == LAST_POS) begin
               pos_q   <= '0;
               valid_o <= frm_ok;
               err_o   <= !frm_ok;
               if (frm_ok)
                  data_o <= frm_nxt.payload;
            end else begin
               pos_q <= pos_q + 1'b1;
            end
         end else if (pos_q != '0) begin
            if (idle_q == TMO_LAST) begin
               pos_q  <= '0;
               idle_q <= '0;
            end else begin
               idle_q <= idle_q + 1'b1;
            end
         end
      end
   end

   // R2: the position never runs past the last frame bit
   assert_pos_range_R2: assert property (@(posedge clk_i) disable iff (rst_i)
      pos_q <= LAST_POS);
   // R8: the two strobes are exclusive and each lasts one cycle
   assert_strobe_excl_R8: assert property (@(posedge clk_i) disable iff (rst_i)
      !(valid_o && err_o));
   assert_valid_pulse_R8: assert property (@(posedge clk_i) disable iff (rst_i)
      valid_o |=> !valid_o);
   assert_err_pulse_R8: assert property (@(posedge clk_i) disable iff (rst_i)
      err_o |=> !err_o);
   // R2: a strobe follows a sample enable
   assert_strobe_cause_R2: assert property (@(posedge clk_i) disable iff (rst_i)
      (valid_o || err_o) |-> $past(sample_i));
   // R9: the byte holds outside a good-frame strobe
   assert_byte_hold_R9: assert property (@(posedge clk_i) disable iff (rst_i)
      !valid_o |-> $stable(data_o));
   // R7: silence past the limit drops the partial frame
   assert_timeout_R7: assert property (@(posedge clk_i) disable iff (rst_i)
      (pos_q != '0 && !sample_i && idle_q == TMO_LAST) |=> (pos_q == '0));

endmodule

// File: rtl/ps2_frame_rx.sv
module ps2_frame_rx
   import ps2rx_pkg::*;
#(
   parameter int RUN_LEN     = 8,
   parameter int SYNC_STAGES = 2,
   parameter int TIMEOUT_CYC = 200000
) (
   input  logic       clk_i,
   input  logic       rst_i,
   input  logic       ps2_clk_i,
   input  logic       ps2_dat_i,
   output logic [7:0] byte_o,
   output logic       byte_valid_o,
   output logic       frame_err_o
);

   initial begin
      assert (DATA_BITS == 8) else $error("byte_o width must match DATA_BITS");
   end

   logic clk_filt;
   logic dat_filt;
   logic bit_tick;

   ps2rx_line_filter #(.RUN_LEN(RUN_LEN), .SYNC_STAGES(SYNC_STAGES)) u_clk_filt (
      .clk_i  (clk_i),
      .rst_i  (rst_i),
      .line_i (ps2_clk_i),
      .line_o (clk_filt)
   );

   ps2rx_line_filter #(.RUN_LEN(RUN_LEN), .SYNC_STAGES(SYNC_STAGES)) u_dat_filt (
      .clk_i  (clk_i),
      .rst_i  (rst_i),
      .line_i (ps2_dat_i),
      .line_o (dat_filt)
   );

   ps2rx_fall_detect u_fall (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .level_i (clk_filt),
      .fall_o  (bit_tick)
   );

   ps2rx_framer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_framer (
      .clk_i    (clk_i),
      .rst_i    (rst_i),
      .sample_i (bit_tick),
      .bit_i    (dat_filt),
      .data_o   (byte_o),
      .valid_o  (byte_valid_o),
      .err_o    (frame_err_o)
   );

endmodule

// File: tb/ps2_frame_rx_tb.sv
module ps2_frame_rx_tb;

   localparam time CLK_PERIOD = 10ns;
   localparam int  HALF       = 40;
   localparam int  TMO        = 600;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       ps2c = 1'b1;
   logic       ps2d = 1'b1;
   logic [7:0] byte_o;
   logic       vld;
   logic       err;

   int checks   = 0;
   int failures = 0;
   int vcnt     = 0;
   int ecnt     = 0;
   logic [7:0] last_byte = 8'h00;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ps2_frame_rx #(.RUN_LEN(8), .SYNC_STAGES(2), .TIMEOUT_CYC(TMO)) u_dut (
      .clk_i        (clk),
      .rst_i        (rst),
      .ps2_clk_i    (ps2c),
      .ps2_dat_i    (ps2d),
      .byte_o       (byte_o),
      .byte_valid_o (vld),
      .frame_err_o  (err)
   );

   always @(negedge clk) begin
      if (!rst) begin
         if (vld) begin
            vcnt++;
            last_byte = byte_o;
         end
         if (err) ecnt++;
      end
   end

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   // one bit: data set while clock high, then a low phase, then high again
   task automatic send_bit(input logic b, input bit clk_glitch, input bit dat_glitch);
      @(negedge clk);
      ps2d = b;
      if (clk_glitch) begin
         wait_cyc(10);
         ps2c = 1'b0;
         wait_cyc(5);
         ps2c = 1'b1;
         wait_cyc(HALF - 15);
      end else begin
         wait_cyc(HALF);
      end
      ps2c = 1'b0;
      if (dat_glitch) begin
         ps2d = ~b;
         wait_cyc(5);
         ps2d = b;
         wait_cyc(HALF - 5);
      end else begin
         wait_cyc(HALF);
      end
      ps2c = 1'b1;
   endtask

   task automatic send_raw(input logic [10:0] bits, input int nbits, input bit glitches);
      for (int i = 0; i < nbits; i++)
         send_bit(bits[i], glitches && (i % 3 == 1), glitches && (i % 2 == 0));
      @(negedge clk);
      ps2d = 1'b1;
      wait_cyc(HALF);
   endtask

   function automatic logic [10:0] mkframe(input logic [7:0] d, input bit bad_start, input bit bad_par, input bit bad_stop);
      logic p;
      p = ~^d;
      if (bad_par) p = ~p;
      return {~bad_stop, p, d, bad_start};
   endfunction

   task automatic expect_good(input logic [10:0] f, input logic [7:0] d, input string req, input bit glitches);
      int v0, e0;
      v0 = vcnt; e0 = ecnt;
      send_raw(f, 11, glitches);
      chk(vcnt - v0 == 1, req, "valid cycles", vcnt - v0, 1);
      chk(ecnt == e0, req, "error strobes", ecnt - e0, 0);
      chk(last_byte == d, req, "byte", last_byte, d);
   endtask

   task automatic expect_bad(input logic [10:0] f, input string req);
      int v0, e0;
      logic [7:0] held;
      v0 = vcnt; e0 = ecnt; held = byte_o;
      send_raw(f, 11, 1'b0);
      chk(ecnt - e0 == 1, req, "error cycles", ecnt - e0, 1);
      chk(vcnt == v0, req, "valid strobes", vcnt - v0, 0);
      chk(byte_o == held, {req, "/R9"}, "byte held", byte_o, held);
   endtask

   task automatic t_reset();
      rst = 1'b1;
      wait_cyc(4);
      chk(vld == 1'b0, "R1", "valid in reset", vld, 0);
      chk(err == 1'b0, "R1", "err in reset", err, 0);
      chk(byte_o == 8'h00, "R1", "byte in reset", byte_o, 0);
      rst = 1'b0;
      wait_cyc(1);
      chk(vld == 1'b0 && err == 1'b0, "R1", "strobes after reset", {vld, err}, 0);
   endtask

   task automatic t_reset_mid_frame();
      send_raw(mkframe(8'h5A, 0, 0, 0), 4, 1'b0);
      rst = 1'b1;
      wait_cyc(3);
      rst = 1'b0;
      wait_cyc(20);
      expect_good(mkframe(8'hC3, 0, 0, 0), 8'hC3, "R1", 1'b0);
   endtask

   task automatic t_good_patterns();
      expect_good(mkframe(8'hA5, 0, 0, 0), 8'hA5, "R2", 1'b0);
      expect_good(mkframe(8'h00, 0, 0, 0), 8'h00, "R2", 1'b0);
      expect_good(mkframe(8'hFF, 0, 0, 0), 8'hFF, "R2", 1'b0);
      expect_good(mkframe(8'h01, 0, 0, 0), 8'h01, "R2", 1'b0);
      expect_good(mkframe(8'h80, 0, 0, 0), 8'h80, "R8", 1'b0);
   endtask

   task automatic t_errors();
      expect_bad(mkframe(8'h3C, 0, 1, 0), "R3");
      expect_bad(mkframe(8'h00, 0, 1, 0), "R3");
      expect_bad(mkframe(8'h77, 1, 0, 0), "R4");
      expect_bad(mkframe(8'h12, 0, 0, 1), "R5");
      expect_good(mkframe(8'h69, 0, 0, 0), 8'h69, "R10", 1'b0);
   endtask

   task automatic t_glitches();
      expect_good(mkframe(8'h96, 0, 0, 0), 8'h96, "R6", 1'b1);
      expect_good(mkframe(8'h4B, 0, 0, 0), 8'h4B, "R6", 1'b1);
   endtask

   task automatic t_timeout();
      int v0, e0;
      v0 = vcnt; e0 = ecnt;
      send_raw(mkframe(8'hE7, 0, 0, 0), 5, 1'b0);
      wait_cyc(TMO + 200);
      chk(vcnt == v0 && ecnt == e0, "R7", "strobes from dropped frame", (vcnt - v0) + (ecnt - e0), 0);
      expect_good(mkframe(8'h2D, 0, 0, 0), 8'h2D, "R7", 1'b0);
   endtask

   initial begin
      repeat (150000) @(negedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      t_reset();
      wait_cyc(20);
      t_good_patterns();
      t_errors();
      t_glitches();
      t_timeout();
      t_reset_mid_frame();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule